// File: doc/BRIEF.md
# UART Transmit and Receive Byte FIFOs with Level Status

This block sits between the register interface of a memory-mapped UART and its serial shifters. It holds two 16-entry byte queues. The bus fills the transmit queue and the transmit shifter drains it. The receive shifter fills the receive queue and the bus drains it. Each queue has its own control word. The control word holds an enable, a flush that clears itself, and a 6-bit trigger threshold that drives an interrupt request.

Software learns the state of both queues from one read-only status word. That word packs the receive fill count, the transmit fill count and the transmit free-slot count into fixed fields. A driver writes transmit bytes only while the free count is nonzero. It treats the transmitter as drained when the transmit fill count reads zero. It reads as many receive bytes as the receive fill count reports. Serial framing and baud timing belong to the shifters and are not part of this block.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset both fill counts are 0, both control words read 0, the status word reads 0x1000_0000 (free count 16), and `tx_irq`, `rx_irq`, `tx_pop_valid` and `rx_overrun` are 0.
- R2: A control word keeps bit 0 (enable) and bits 13:8 (trigger level) of the value written. It reads back with every other bit 0, including bit 1 (flush).
- R3: Writing a control word with bit 1 set empties that queue at the same clock edge. The enable and trigger fields still take the written values.
- R4: The status word carries the receive fill count in bits 5:0, the transmit fill count in bits 13:8 and the transmit free count in bits 29:24, with all other bits 0. The free count always equals 16 minus the transmit fill count.
- R5: Bytes written by the bus leave on `tx_pop_data` in write order. `tx_pop_valid` is 1 only while the transmit queue is enabled and not empty. A byte is removed on a clock edge where both `tx_pop_valid` and `tx_pop_ready` are 1.
- R6: A transmit write while 16 bytes are held is dropped: the fill count stays 16, the free count stays 0, and the stored bytes are unchanged.
- R7: Bytes pushed by the receive shifter are read by the bus in push order. `rx_rdata` shows the oldest byte, and asserting `rxd_re` removes it at the next edge.
- R8: A receive push while 16 bytes are held is dropped. `rx_overrun` is 1 for exactly the one cycle after that edge.
- R9: A bus read of an empty receive queue gives `rx_rdata` = 0 and leaves the fill count at 0.
- R10: `rx_irq` is 1 when the receive queue is enabled and its fill count is at or above its trigger level. `tx_irq` is 1 when the transmit queue is enabled and its fill count is at or below its trigger level.
- R11: While a queue's enable bit is 0, writes, pushes and pops on it have no effect on its fill count, its interrupt request is 0 and `tx_pop_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for a control word |
| cfg_sel | input | 1 | Control word select: 0 transmit, 1 receive |
| cfg_wdata | input | 32 | Control word write value |
| tx_ctrl | output | 32 | Transmit control word readback |
| rx_ctrl | output | 32 | Receive control word readback |
| status | output | 32 | Packed level status word |
| txd_we | input | 1 | Bus write strobe for a transmit byte |
| txd_wdata | input | 8 | Transmit byte from the bus |
| rxd_re | input | 1 | Bus read strobe that removes the oldest receive byte |
| rx_rdata | output | 8 | Oldest receive byte, 0 when empty |
| tx_pop_valid | output | 1 | Transmit byte available to the shifter |
| tx_pop_ready | input | 1 | Shifter takes the transmit byte |
| tx_pop_data | output | 8 | Oldest transmit byte |
| rx_push_valid | input | 1 | Receive shifter delivers a byte |
| rx_push_data | input | 8 | Received byte |
| rx_overrun | output | 1 | One-cycle pulse after a dropped receive push |
| tx_irq | output | 1 | Transmit trigger request |
| rx_irq | output | 1 | Receive trigger request |

## Verification
All fill counts, control readbacks and pointer moves change at the first clock edge after the strobe. The status word and both interrupt requests follow the counts with no added register, so they are due in the same cycle. The head bytes `rx_rdata` and `tx_pop_data` are valid before the strobe that removes them. The overrun pulse appears in the one cycle after the dropped push. The bench drives every strobe for one cycle starting at a falling edge, and samples at the following falling edge. It checks the head byte before it asserts the read or pop strobe. It checks the overrun output both in that cycle and in the cycle after, to show it lasts exactly one cycle.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
    localparam int BYTE_W  = 8;
    localparam int LVL_W   = 6;
    localparam int Q_DEPTH = 16;

    // enable and trigger level held for one queue
    typedef struct packed {
        logic [LVL_W-1:0] trig;
        logic             en;
    } qcfg_t;

    // control word readback: trigger in 13:8, enable in 0, flush always 0
    function automatic logic [31:0] ctrl_word(qcfg_t c);
        logic [31:0] w;
        w        = '0;
        w[0]     = c.en;
        w[13:8]  = c.trig;
        return w;
    endfunction

    // status: rx fill 5:0, tx fill 13:8, tx free 29:24
    function automatic logic [31:0] pack_status(logic [LVL_W-1:0] rx_fill,
                                                logic [LVL_W-1:0] tx_fill,
                                                logic [LVL_W-1:0] tx_free);
        logic [31:0] w;
        w        = '0;
        w[5:0]   = rx_fill;
        w[13:8]  = tx_fill;
        w[29:24] = tx_free;
        return w;
    endfunction
endpackage

// File: rtl/uart_fifo_cfg.sv
module uart_fifo_cfg
    import uart_fifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             en_in,
    input  logic             flush_in,
    input  logic [LVL_W-1:0] trig_in,
    output qcfg_t            cfg,
    output logic             flush
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            cfg.en   <= en_in;
            cfg.trig <= trig_in;
        end
    end

    // flush is never stored: it acts at the edge of the write
    assign flush = we & flush_in;
endmodule

// File: rtl/uart_fifo_core.sv
module uart_fifo_core #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int LW    = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [LW-1:0] level,
    output logic          drop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [LW-1:0]    FULL_LVL = LW'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full, empty, do_push, do_pop;

    assign full    = (level == FULL_LVL);
    assign empty   = (level == '0);
    assign do_push = en & push & ~full & ~flush;
    assign do_pop  = en & pop & ~empty & ~flush;
    assign drop    = en & push & full & ~flush;
    assign head    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R3: flush empties the queue at its edge
    a_r3_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (level == '0));
    // R6 / R8: a push into a full queue with no pop leaves it full
    a_r6_full_holds: assert property (@(posedge clk) disable iff (rst)
        (en && push && full && !pop && !flush) |=> (level == FULL_LVL));
    // R9: popping an empty queue keeps it empty
    a_r9_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (en && pop && empty && !push && !flush) |=> (level == '0));
    // R11: a disabled queue keeps its level
    a_r11_disabled_stable: assert property (@(posedge clk) disable iff (rst)
        (!en && !flush) |=> $stable(level));
    // R4: level never exceeds depth
    a_r4_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= FULL_LVL);
endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
    import uart_fifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic        cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] tx_ctrl,
    output logic [31:0] rx_ctrl,
    output logic [31:0] status,
    input  logic        txd_we,
    input  logic [7:0]  txd_wdata,
    input  logic        rxd_re,
    output logic [7:0]  rx_rdata,
    output logic        tx_pop_valid,
    input  logic        tx_pop_ready,
    output logic [7:0]  tx_pop_data,
    input  logic        rx_push_valid,
    input  logic [7:0]  rx_push_data,
    output logic        rx_overrun,
    output logic        tx_irq,
    output logic        rx_irq
);
    localparam int N_Q = 2;
    localparam int QTX = 0;
    localparam int QRX = 1;
    localparam logic [LVL_W-1:0] DEPTH_LVL = LVL_W'(Q_DEPTH);

    qcfg_t              qcfg   [N_Q];
    logic               qflush [N_Q];
    logic               qpush  [N_Q];
    logic               qpop   [N_Q];
    logic [BYTE_W-1:0]  qdin   [N_Q];
    logic [BYTE_W-1:0]  qhead  [N_Q];
    logic [LVL_W-1:0]   qlvl   [N_Q];
    logic               qdrop  [N_Q];
    logic [LVL_W-1:0]   tx_free;
    logic               unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_wdata[31:14], cfg_wdata[7:2]};

    assign qpush[QTX] = txd_we;
    assign qdin[QTX]  = txd_wdata;
    assign qpop[QTX]  = tx_pop_ready;
    assign qpush[QRX] = rx_push_valid;
    assign qdin[QRX]  = rx_push_data;
    assign qpop[QRX]  = rxd_re;

    for (genvar q = 0; q < N_Q; q++) begin : g_q
        uart_fifo_cfg u_cfg (
            .clk      (clk),
            .rst      (rst),
            .we       (cfg_we && (cfg_sel == q[0])),
            .en_in    (cfg_wdata[0]),
            .flush_in (cfg_wdata[1]),
            .trig_in  (cfg_wdata[13:8]),
            .cfg      (qcfg[q]),
            .flush    (qflush[q])
        );
        uart_fifo_core #(.DEPTH(Q_DEPTH), .DW(BYTE_W), .LW(LVL_W)) u_core (
            .clk       (clk),
            .rst       (rst),
            .en        (qcfg[q].en),
            .flush     (qflush[q]),
            .push      (qpush[q]),
            .push_data (qdin[q]),
            .pop       (qpop[q]),
            .head      (qhead[q]),
            .level     (qlvl[q]),
            .drop      (qdrop[q])
        );
    end

    assign tx_free      = DEPTH_LVL - qlvl[QTX];
    assign status       = pack_status(qlvl[QRX], qlvl[QTX], tx_free);
    assign tx_ctrl      = ctrl_word(qcfg[QTX]);
    assign rx_ctrl      = ctrl_word(qcfg[QRX]);
    assign tx_pop_valid = qcfg[QTX].en && (qlvl[QTX] != '0);
    assign tx_pop_data  = qhead[QTX];
    assign rx_rdata     = qhead[QRX];
    assign rx_irq       = qcfg[QRX].en && (qlvl[QRX] >= qcfg[QRX].trig);
    assign tx_irq       = qcfg[QTX].en && (qlvl[QTX] <= qcfg[QTX].trig);

    always_ff @(posedge clk) begin
        if (rst) rx_overrun <= 1'b0;
        else     rx_overrun <= qdrop[QRX];
    end

    // R4: free and fill fields always sum to the depth
    a_r4_free_plus_fill: assert property (@(posedge clk) disable iff (rst)
        ({2'b00, status[29:24]} + {2'b00, status[13:8]}) == 8'(Q_DEPTH));
    // R8: an overrun pulse follows a receive push
    a_r8_overrun_cause: assert property (@(posedge clk) disable iff (rst)
        rx_overrun |-> $past(rx_push_valid));
    // R8: the pulse lasts one cycle unless pushes keep overflowing
    a_r8_overrun_pulse: assert property (@(posedge clk) disable iff (rst)
        (rx_overrun && !rx_push_valid) |=> !rx_overrun);
    // R5: nothing offered from an empty transmit queue
    a_r5_valid_nonempty: assert property (@(posedge clk) disable iff (rst)
        tx_pop_valid |-> (status[13:8] != 6'd0));
    // R2: flush never reads back
    a_r2_flush_reads_zero: assert property (@(posedge clk) disable iff (rst)
        !tx_ctrl[1] && !rx_ctrl[1]);
    // R10 / R11: requests quiet while the queue is disabled
    a_r11_irq_gated: assert property (@(posedge clk) disable iff (rst)
        (!tx_ctrl[0] |-> !tx_irq) and (!rx_ctrl[0] |-> !rx_irq));
endmodule

// File: tb/uart_fifo_pair_tb.sv
module uart_fifo_pair_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] tx_ctrl, rx_ctrl, status;
    logic        txd_we = 1'b0;
    logic [7:0]  txd_wdata = '0;
    logic        rxd_re = 1'b0;
    logic [7:0]  rx_rdata;
    logic        tx_pop_valid;
    logic        tx_pop_ready = 1'b0;
    logic [7:0]  tx_pop_data;
    logic        rx_push_valid = 1'b0;
    logic [7:0]  rx_push_data = '0;
    logic        rx_overrun, tx_irq, rx_irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    uart_fifo_pair u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .tx_ctrl(tx_ctrl), .rx_ctrl(rx_ctrl),
        .status(status), .txd_we(txd_we), .txd_wdata(txd_wdata),
        .rxd_re(rxd_re), .rx_rdata(rx_rdata), .tx_pop_valid(tx_pop_valid),
        .tx_pop_ready(tx_pop_ready), .tx_pop_data(tx_pop_data),
        .rx_push_valid(rx_push_valid), .rx_push_data(rx_push_data),
        .rx_overrun(rx_overrun), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    function automatic logic [31:0] exp_status(int rxl, int txl);
        return (32'(16 - txl) << 24) | (32'(txl) << 8) | 32'(rxl);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic sel, logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic tx_write(logic [7:0] b);
        @(negedge clk);
        txd_we = 1'b1; txd_wdata = b;
        @(negedge clk);
        txd_we = 1'b0;
    endtask

    task automatic rx_push(logic [7:0] b);
        @(negedge clk);
        rx_push_valid = 1'b1; rx_push_data = b;
        @(negedge clk);
        rx_push_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 status", status, 32'h1000_0000);
        chk("R1 tx_ctrl", tx_ctrl, 0);
        chk("R1 rx_ctrl", rx_ctrl, 0);
        chk("R1 outputs", {28'd0, tx_irq, rx_irq, tx_pop_valid, rx_overrun}, 0);
    endtask

    task automatic t_disabled;
        tx_write(8'h55);
        rx_push(8'h66);
        chk("R11 disabled levels", status, exp_status(0, 0));
        chk("R11 disabled valid/irq", {29'd0, tx_pop_valid, tx_irq, rx_irq}, 0);
    endtask

    task automatic t_cfg;
        cfg_write(1'b0, 32'h8000_0403 | 32'h0000_00F0);
        chk("R2 tx readback", tx_ctrl, 32'h0000_0401);
        cfg_write(1'b1, 32'h0000_0301);
        chk("R2 rx readback", rx_ctrl, 32'h0000_0301);
        chk("R10 tx_irq empty<=4", {31'd0, tx_irq}, 1);
    endtask

    task automatic t_tx_order;
        tx_write(8'hA1); tx_write(8'hB2); tx_write(8'hC3);
        chk("R4 status tx=3", status, exp_status(0, 3));
        chk("R10 tx_irq 3<=4", {31'd0, tx_irq}, 1);
        chk("R5 valid", {31'd0, tx_pop_valid}, 1);
        for (int i = 0; i < 3; i++) begin
            logic [7:0] e;
            e = (i == 0) ? 8'hA1 : (i == 1) ? 8'hB2 : 8'hC3;
            chk("R5 pop order", {24'd0, tx_pop_data}, {24'd0, e});
            tx_pop_ready = 1'b1;
            @(negedge clk);
            tx_pop_ready = 1'b0;
        end
        chk("R5 drained", status, exp_status(0, 0));
        chk("R5 valid low", {31'd0, tx_pop_valid}, 0);
    endtask

    task automatic t_tx_full;
        for (int i = 0; i < 17; i++) tx_write(8'(8'h10 + i));
        chk("R6 full status", status, exp_status(0, 16));
        chk("R10 tx_irq 16>4", {31'd0, tx_irq}, 0);
        chk("R6 head kept", {24'd0, tx_pop_data}, 32'h10);
        cfg_write(1'b0, 32'h0000_0603);
        chk("R3 tx flush", status, exp_status(0, 0));
        chk("R3 ctrl after flush", tx_ctrl, 32'h0000_0601);
        for (int i = 0; i < 16; i++) tx_write(8'(8'h40 + i));
        for (int i = 0; i < 15; i++) begin
            tx_pop_ready = 1'b1;
            @(negedge clk);
        end
        tx_pop_ready = 1'b0;
        chk("R6 last byte kept", {24'd0, tx_pop_data}, 32'h4F);
        cfg_write(1'b0, 32'h0000_0403);
    endtask

    task automatic t_rx;
        rx_push(8'h01); rx_push(8'h02);
        chk("R10 rx_irq 2<3", {31'd0, rx_irq}, 0);
        rx_push(8'h03);
        chk("R10 rx_irq 3>=3", {31'd0, rx_irq}, 1);
        chk("R4 status rx=3", status, exp_status(3, 0));
        for (int i = 1; i <= 3; i++) begin
            chk("R7 read order", {24'd0, rx_rdata}, 32'(i));
            @(negedge clk);
            rxd_re = 1'b1;
            @(negedge clk);
            rxd_re = 1'b0;
        end
        chk("R9 empty data", {24'd0, rx_rdata}, 0);
        @(negedge clk);
        rxd_re = 1'b1;
        @(negedge clk);
        rxd_re = 1'b0;
        chk("R9 empty level", status, exp_status(0, 0));
    endtask

    task automatic t_overrun;
        for (int i = 0; i < 16; i++) rx_push(8'(8'h80 + i));
        chk("R8 no overrun when filling", {31'd0, rx_overrun}, 0);
        rx_push(8'hEE);
        chk("R8 overrun pulse", {31'd0, rx_overrun}, 1);
        chk("R8 level held", status, exp_status(16, 0));
        @(negedge clk);
        chk("R8 pulse one cycle", {31'd0, rx_overrun}, 0);
        chk("R8 head kept", {24'd0, rx_rdata}, 32'h80);
        cfg_write(1'b1, 32'h0000_0303);
        chk("R3 rx flush", status, exp_status(0, 0));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_cfg();
        t_tx_order();
        t_tx_full();
        t_rx();
        t_overrun();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule